// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This is a purely combinational execution slice for an 8-bit processor core. It takes the second byte of a bit-operation prefix instruction and decodes it. It then applies one of eight rotate/shift kinds, a single-bit test, a single-bit clear or a single-bit set to an 8-bit operand. It returns the new value, the new flag byte, a write enable for the result, and the 3-bit register field taken from the byte. The register file, index arithmetic and memory cycles stay in the surrounding core. That logic reads the register field to fetch the operand and to write back the result.

A mode input reuses the same datapath for the four one-byte accumulator rotates. In that mode the byte carries the short opcode. Bits 4..3 pick the rotate kind. The sign, zero and parity flags pass through unchanged.

Top module: `rotbit_unit`

## Requirements
- R1: With `shortRot`=0, opcode bits 7..6 choose the class: 00 rotate/shift, 01 bit test, 10 bit clear, 11 bit set. For class 00, bits 5..3 choose the kind: 0 RLC, 1 RRC, 2 RL, 3 RR, 4 SLA, 5 SRA, 6 SLL, 7 SRL. For the other classes, bits 5..3 give the bit index.
- R2: With `shortRot`=0, `regSel` equals opcode bits 2..0 (0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 memory operand, 7 A). With `shortRot`=1, `regSel` is 7.
- R3: RLC and RRC move the outgoing end bit into the opposite end. RL and RR put `carryIn` into the vacated bit. The carry flag receives the bit shifted out (bit 7 for left moves, bit 0 for right moves).
- R4: SLA puts 0 into bit 0. SLL puts 1 into bit 0. SRA keeps bit 7. SRL puts 0 into bit 7. The carry flag receives the bit shifted out.
- R5: The flag byte uses bit 7 S, 6 Z, 4 H, 2 P/V, 1 N and 0 C. Bits 5 and 3 are always copied from `flagsIn`. A prefixed rotate/shift sets S to result bit 7 and Z to (result==0). It clears H and N, and sets P/V to 1 when the result has an even number of ones.
- R6: With `shortRot`=1, opcode bits 4..3 choose RLC, RRC, RL or RR (values 0..3) and the result follows R3. H and N clear, C takes the shifted-out bit, and S, Z and P/V are copied from `flagsIn`.
- R7: A bit test sets Z to the inverse of operand bit b. It sets S to that bit when b=7 and to 0 otherwise. P/V equals Z, H is 1, N is 0 and C is copied from `flagsIn`. `writeEn` is 0 and `result` equals the operand.
- R8: A bit clear or bit set returns the operand with bit b forced to 0 or to 1, every other bit unchanged. `flagsOut` equals `flagsIn` and `writeEn` is 1.
- R9: `writeEn` is 1 for every rotate/shift, prefixed or short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 8 | Second byte of the prefixed opcode, or the short rotate opcode |
| operand | input | 8 | Value read by the core from the selected register or memory |
| carryIn | input | 1 | Carry fed into RL/RR |
| flagsIn | input | 8 | Current flag byte |
| shortRot | input | 1 | 1 selects the accumulator short rotate mode |
| result | output | 8 | Computed value |
| flagsOut | output | 8 | New flag byte |
| writeEn | output | 1 | 1 when the result is to be written back |
| regSel | output | 3 | Register field for operand and write-back |

## Verification
Two functions can act together. The short-rotate mode can meet an opcode byte whose upper bits would decode as a prefixed bit test, clear or set. The bench drives `shortRot`=1 with all 256 byte values, so high bits and register fields that would otherwise select other operations are present. It then judges that only bits 4..3 matter, that the result is a rotate, and that S, Z and P/V equal the incoming flags. In prefixed mode, a sweep over every opcode, several operand patterns and both carry values compares result, flags, write enable and register field against an independent model.

// File: rtl/rotbit_pkg.sv
package rotbit_pkg;
  localparam int DATA_W  = 8;
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int FLAG_W  = 8;
  localparam int F_S     = 7;
  localparam int F_Z     = 6;
  localparam int F_H     = 4;
  localparam int F_P     = 2;
  localparam int F_N     = 1;
  localparam int F_C     = 0;
  localparam logic [IDX_W-1:0] REG_ACC = IDX_W'(7);

  typedef enum logic [1:0] {
    CL_SHIFT = 2'b00,
    CL_TEST  = 2'b01,
    CL_CLR   = 2'b10,
    CL_SET   = 2'b11
  } opClass_e;

  typedef enum logic [2:0] {
    K_RLC = 3'd0, K_RRC = 3'd1, K_RL  = 3'd2, K_RR  = 3'd3,
    K_SLA = 3'd4, K_SRA = 3'd5, K_SLL = 3'd6, K_SRL = 3'd7
  } shiftKind_e;

  typedef struct packed {
    opClass_e         opClass;
    shiftKind_e       kind;
    logic [IDX_W-1:0] bitIdx;
    logic             shortForm;
  } ctrl_t;
endpackage

// File: rtl/rotbit_ctrl.sv
module rotbit_ctrl
  import rotbit_pkg::*;
(
  input  logic [DATA_W-1:0] opCode,
  input  logic              shortRot,
  output ctrl_t             ctrl,
  output logic [IDX_W-1:0]  regSel,
  output logic              writeEn
);
  always_comb begin
    ctrl.shortForm = shortRot;
    ctrl.bitIdx    = opCode[5:3];
    if (shortRot) begin
      ctrl.opClass = CL_SHIFT;
      ctrl.kind    = shiftKind_e'({1'b0, opCode[4:3]});
      regSel       = REG_ACC;
    end else begin
      ctrl.opClass = opClass_e'(opCode[7:6]);
      ctrl.kind    = shiftKind_e'(opCode[5:3]);
      regSel       = opCode[2:0];
    end
    writeEn = (ctrl.opClass != CL_TEST);
  end
endmodule

// File: rtl/rotbit_dpath.sv
module rotbit_dpath
  import rotbit_pkg::*;
(
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shiftRes;
  logic [DATA_W-1:0] bitRes;
  logic              shiftOut;
  logic              testBit;

  always_comb begin
    unique case (ctrl.kind)
      K_RLC: begin shiftRes = {operand[MSB-1:0], operand[MSB]}; shiftOut = operand[MSB]; end
      K_RRC: begin shiftRes = {operand[0], operand[MSB:1]};     shiftOut = operand[0];   end
      K_RL:  begin shiftRes = {operand[MSB-1:0], carryIn};      shiftOut = operand[MSB]; end
      K_RR:  begin shiftRes = {carryIn, operand[MSB:1]};        shiftOut = operand[0];   end
      K_SLA: begin shiftRes = {operand[MSB-1:0], 1'b0};         shiftOut = operand[MSB]; end
      K_SRA: begin shiftRes = {operand[MSB], operand[MSB:1]};   shiftOut = operand[0];   end
      K_SLL: begin shiftRes = {operand[MSB-1:0], 1'b1};         shiftOut = operand[MSB]; end
      default: begin shiftRes = {1'b0, operand[MSB:1]};         shiftOut = operand[0];   end
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitop
    assign bitRes[i] = (ctrl.bitIdx == IDX_W'(i)) ? (ctrl.opClass == CL_SET) : operand[i];
  end

  assign testBit = operand[ctrl.bitIdx];

  always_comb begin
    flagsOut = flagsIn;
    result   = bitRes;
    unique case (ctrl.opClass)
      CL_SHIFT: begin
        result         = shiftRes;
        flagsOut[F_H]  = 1'b0;
        flagsOut[F_N]  = 1'b0;
        flagsOut[F_C]  = shiftOut;
        if (!ctrl.shortForm) begin
          flagsOut[F_S] = shiftRes[MSB];
          flagsOut[F_Z] = (shiftRes == '0);
          flagsOut[F_P] = ~^shiftRes;
        end
      end
      CL_TEST: begin
        result        = operand;
        flagsOut[F_Z] = ~testBit;
        flagsOut[F_S] = (ctrl.bitIdx == IDX_W'(MSB)) & testBit;
        flagsOut[F_P] = ~testBit;
        flagsOut[F_H] = 1'b1;
        flagsOut[F_N] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rotbit_unit.sv
module rotbit_unit
  import rotbit_pkg::*;
(
  input  logic [7:0] opCode,
  input  logic [7:0] operand,
  input  logic       carryIn,
  input  logic [7:0] flagsIn,
  input  logic       shortRot,
  output logic [7:0] result,
  output logic [7:0] flagsOut,
  output logic       writeEn,
  output logic [2:0] regSel
);
  ctrl_t ctrl;

  rotbit_ctrl u_ctrl (
    .opCode  (opCode),
    .shortRot(shortRot),
    .ctrl    (ctrl),
    .regSel  (regSel),
    .writeEn (writeEn)
  );

  rotbit_dpath u_dpath (
    .ctrl    (ctrl),
    .operand (operand),
    .carryIn (carryIn),
    .flagsIn (flagsIn),
    .result  (result),
    .flagsOut(flagsOut)
  );
endmodule

// File: rtl/rotbit_unit_chk.sv
module rotbit_unit_chk (
  input logic [7:0] opCode,
  input logic [7:0] operand,
  input logic       carryIn,
  input logic [7:0] flagsIn,
  input logic       shortRot,
  input logic [7:0] result,
  input logic [7:0] flagsOut,
  input logic       writeEn,
  input logic [2:0] regSel
);
  logic known;
  logic [7:0] bitMask;
  assign known   = !$isunknown({opCode, operand, carryIn, flagsIn, shortRot});
  assign bitMask = 8'd1 << opCode[5:3];

  always_comb begin
    if (known) begin
      AST_REG_FIELD: assert (regSel == (shortRot ? 3'd7 : opCode[2:0]))
        else $error("register field mismatch"); // R2
      AST_SHORT_KEEPS_SZP: assert (!shortRot ||
          (flagsOut[7] == flagsIn[7] && flagsOut[6] == flagsIn[6] &&
           flagsOut[2] == flagsIn[2] && writeEn))
        else $error("short rotate disturbed S/Z/P"); // R6
      AST_SHIFT_FLAGS: assert (shortRot || opCode[7:6] != 2'b00 ||
          (flagsOut[4] == 1'b0 && flagsOut[1] == 1'b0 &&
           flagsOut[6] == (result == 8'd0) && flagsOut[2] == ~^result &&
           flagsOut[7] == result[7] && writeEn))
        else $error("prefixed shift flags wrong"); // R5
      AST_TEST_NO_WRITE: assert (shortRot || opCode[7:6] != 2'b01 ||
          (!writeEn && flagsOut[4] && flagsOut[0] == flagsIn[0] &&
           result == operand && flagsOut[6] == ((operand & bitMask) == 8'd0)))
        else $error("bit test misbehaved"); // R7
      AST_BIT_WRITE: assert (shortRot || !opCode[7] ||
          (writeEn && flagsOut == flagsIn &&
           (result & ~bitMask) == (operand & ~bitMask) &&
           ((result & bitMask) != 8'd0) == opCode[6]))
        else $error("bit set/clear wrong"); // R8
      AST_UNDOC_BITS: assert (flagsOut[5] == flagsIn[5] && flagsOut[3] == flagsIn[3])
        else $error("bits 5/3 changed"); // R5
    end
  end
endmodule

bind rotbit_unit rotbit_unit_chk u_rotbit_chk (
  .opCode  (opCode),
  .operand (operand),
  .carryIn (carryIn),
  .flagsIn (flagsIn),
  .shortRot(shortRot),
  .result  (result),
  .flagsOut(flagsOut),
  .writeEn (writeEn),
  .regSel  (regSel)
);

// File: tb/rotbit_unit_bench.sv
module rotbit_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    logic       we;
    logic [2:0] reg3;
    string      resTag;
    string      flgTag;
    string      weTag;
  } item_t;

  logic       clk = 1'b0;
  logic [7:0] opCode = '0;
  logic [7:0] operand = '0;
  logic       carryIn = 1'b0;
  logic [7:0] flagsIn = '0;
  logic       shortRot = 1'b0;
  logic [7:0] result;
  logic [7:0] flagsOut;
  logic       writeEn;
  logic [2:0] regSel;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rotbit_unit u_rotbit_unit (
    .opCode(opCode), .operand(operand), .carryIn(carryIn), .flagsIn(flagsIn),
    .shortRot(shortRot), .result(result), .flagsOut(flagsOut),
    .writeEn(writeEn), .regSel(regSel)
  );

  function automatic item_t model(input logic [7:0] op, input logic [7:0] v,
                                  input logic ci, input logic [7:0] fi, input logic sm);
    item_t it;
    int kind, b;
    logic co, tb;
    logic [7:0] r;
    it.flg = fi;
    b = int'(op[5:3]);
    kind = sm ? int'(op[4:3]) : int'(op[5:3]);
    it.reg3 = sm ? 3'd7 : op[2:0];
    if (sm || op[7:6] == 2'b00) begin
      co = (kind % 2 == 0) ? v[7] : v[0];
      case (kind)
        0: r = (v << 1) | (v >> 7);
        1: r = (v >> 1) | (v << 7);
        2: r = (v << 1) | {7'd0, ci};
        3: r = (v >> 1) | {ci, 7'd0};
        4: r = v << 1;
        5: r = (v >> 1) | (v & 8'h80);
        6: r = (v << 1) | 8'h01;
        default: r = v >> 1;
      endcase
      it.res = r;
      it.we  = 1'b1;
      it.flg[4] = 1'b0; it.flg[1] = 1'b0; it.flg[0] = co;
      if (!sm) begin
        it.flg[7] = r[7];
        it.flg[6] = (r == 0);
        it.flg[2] = ($countones(r) % 2 == 0);
        it.flgTag = "R5";
        it.resTag = (kind < 4) ? "R1 R3" : "R1 R4";
      end else begin
        it.flgTag = "R6";
        it.resTag = "R6 R3";
      end
      it.weTag = "R9";
    end else if (op[7:6] == 2'b01) begin
      tb = v[b];
      it.res = v;
      it.we  = 1'b0;
      it.flg[6] = !tb;
      it.flg[7] = (b == 7) && tb;
      it.flg[2] = !tb;
      it.flg[4] = 1'b1;
      it.flg[1] = 1'b0;
      it.resTag = "R1 R7"; it.flgTag = "R7"; it.weTag = "R7";
    end else begin
      r = v;
      r[b] = op[6];
      it.res = r;
      it.we  = 1'b1;
      it.resTag = "R1 R8"; it.flgTag = "R8"; it.weTag = "R8";
    end
    return it;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] v,
                       input logic ci, input logic [7:0] fi, input logic sm);
    @(negedge clk);
    opCode = op; operand = v; carryIn = ci; flagsIn = fi; shortRot = sm;
    expQ.push_back(model(op, v, ci, fi, sm));
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp,
                        input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s op=%02h sm=%0b actual=%02h expected=%02h",
               tag, what, opCode, shortRot, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      check8(it.resTag, result, it.res, "result");
      check8(it.flgTag, flagsOut, it.flg, "flags");
      check8(it.weTag, {7'd0, writeEn}, {7'd0, it.we}, "writeEn");
      check8("R2", {5'd0, regSel}, {5'd0, it.reg3}, "regSel");
    end
  end

  initial begin
    logic [7:0] vals [6];
    logic [7:0] flgs [3];
    vals[0] = 8'h00; vals[1] = 8'h80; vals[2] = 8'h01;
    vals[3] = 8'hA5; vals[4] = 8'hFF; vals[5] = 8'h5A;
    flgs[0] = 8'h00; flgs[1] = 8'hFF; flgs[2] = 8'h28;
    // R1 R2 R3 R4 R5 R7 R8 R9: prefixed sweep over every opcode
    for (int op = 0; op < 256; op++)
      for (int vi = 0; vi < 6; vi++)
        drive(8'(op), vals[vi], vi[0], flgs[(op + vi) % 3], 1'b0);
    // R6: short mode with all byte values, upper bits must not matter
    for (int op = 0; op < 256; op++)
      for (int vi = 0; vi < 3; vi++)
        drive(8'(op), vals[vi * 2 + 1], op[0], (vi == 1) ? 8'hC4 : flgs[vi], 1'b1);
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule